// File: doc/BRIEF.md
# Dual-Slope Centre-Aligned PWM Generator

This block is an 8-bit up/down timer that drives one pulse-width-modulated output. The timer climbs from zero to its top value and then falls back to zero. Each pass through the compare value changes the output: on the way up it moves the output one way, and on the way down it moves it the other way. The pulse is therefore symmetric about the zero point of the count. A full cycle takes 510 timer ticks. A clock prescaler sets the tick rate.

Software writes a compare value into a holding register. The running timer picks up that value only at its turn-round at the top, so a period never sees a half-updated threshold. Two sticky flags report events: one marks a compare hit and the other marks arrival at zero. Each flag has its own clear input.

Top module: `pcpwm_top`

## Requirements
- R1: `clkSel` picks the tick rate. Code 1 gives a tick on every clock, code 2 every 8 clocks, code 3 every 64, code 4 every 256 and code 5 every 1024. Codes 0, 6 and 7 give no ticks. The divider is held cleared while `enable` is low, so with divide-by-N the first tick falls on the Nth rising clock edge that sees `enable` high.
- R2: On successive ticks the count goes 0, 1, …, 255, 254, …, 1, 0, 1, … and so on. Each end value lasts exactly one tick, so the triangle repeats every 510 ticks.
- R3: `ovfFlag` is set on any tick taken while the count is 0. It stays set until `ovfClr` is high on a clock edge. When a set and a clear arrive on the same edge, the set wins.
- R4: `matchFlag` is set on any tick taken while the count equals the active compare value, in either direction. It holds and clears in the same way as `ovfFlag`, through `matchClr`.
- R5: With `cmpMode` = 2, a compare hit while the count rises drives the output low, and a hit while the count falls drives it high. Once a value k is active, the output is high for 2·k ticks out of every 510.
- R6: With `cmpMode` = 3, the levels are swapped: a rising-count hit drives the output high and a falling-count hit drives it low.
- R7: With `cmpMode` = 0 or 1, `pwmOut` is held low. The timer and both flags keep running.
- R8: A write through `cmpWrEn`/`cmpWrData` lands in a holding register. The active compare value loads from it on the tick taken while the count is 255. The load uses the holding value as it stood before any write on that same edge, and a write at any other time leaves the threshold of the current period unchanged.
- R9: With `cmpMode` = 2, an active value of 0 keeps the output low and an active value of 255 keeps it high. With `cmpMode` = 3 the opposite levels hold. Both apply once the first hit under that value has occurred.
- R10: After reset the count is 0 and rising, the active and holding compare values are 0, and `pwmOut`, `matchFlag` and `ovfFlag` are low.
- R11: While `enable` is low, the count, the output level and the flags stay frozen, except for clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the prescaler and the timer |
| clkSel | input | 3 | Tick-rate select (R1 codes) |
| cmpMode | input | 2 | Output mode: 0/1 off, 2 non-inverted, 3 inverted |
| cmpWrEn | input | 1 | Writes `cmpWrData` into the holding register |
| cmpWrData | input | 8 | New compare value |
| matchClr | input | 1 | Clears `matchFlag` |
| ovfClr | input | 1 | Clears `ovfFlag` |
| pwmOut | output | 1 | PWM waveform |
| matchFlag | output | 1 | Sticky compare-hit flag |
| ovfFlag | output | 1 | Sticky count-at-zero flag |

## Verification
The properties assume that `cmpMode` does not change while the timer runs. This matters because a mode change alters the output without any tick. The stimulus therefore sets the mode only while reset is asserted or before `enable` rises. The properties also assume that `clkSel` stays fixed between resets, so the tick spacing seen by a test is constant. Every test selects its rate before enabling and never changes it mid-run. The flag properties assume that a clear input lasts one cycle at a time. The bench raises a clear only on the cycle after it sees a flag set.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

  typedef enum logic [2:0] {
    SEL_STOP    = 3'd0,
    SEL_DIV1    = 3'd1,
    SEL_DIV8    = 3'd2,
    SEL_DIV64   = 3'd3,
    SEL_DIV256  = 3'd4,
    SEL_DIV1024 = 3'd5,
    SEL_RSV6    = 3'd6,
    SEL_RSV7    = 3'd7
  } clkSel_e;

  typedef enum logic [1:0] {
    MODE_OFF0   = 2'd0,
    MODE_OFF1   = 2'd1,
    MODE_NONINV = 2'd2,
    MODE_INV    = 2'd3
  } outMode_e;

  // Strobes from control to datapath, one cycle wide each
  typedef struct packed {
    logic tick;
    logic stepUp;
    logic stepDown;
    logic loadCmp;
    logic setOut;
    logic clrOut;
    logic setMatch;
    logic setOvf;
    logic outEn;
  } pwmStrobes_t;

endpackage

// File: rtl/pcpwm_prescale.sv
module pcpwm_prescale #(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [2:0] clkSel,
  output logic       tick
);
  import pcpwm_pkg::*;

  localparam int NUM_TAPS = 4;

  function automatic int tapOf(int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

  logic [PRE_W-1:0]    preDiv;
  logic [NUM_TAPS-1:0] wrapAt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        preDiv <= '0;
    else if (!enable) preDiv <= '0;
    else              preDiv <= preDiv + PRE_W'(1);
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam int TAP = tapOf(g);
    assign wrapAt[g] = &preDiv[TAP-1:0];
  end

  always_comb begin
    tick = 1'b0;
    if (enable) begin
      case (clkSel_e'(clkSel))
        SEL_DIV1:    tick = 1'b1;
        SEL_DIV8:    tick = wrapAt[0];
        SEL_DIV64:   tick = wrapAt[1];
        SEL_DIV256:  tick = wrapAt[2];
        SEL_DIV1024: tick = wrapAt[3];
        default:     tick = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/pcpwm_ctrl.sv
module pcpwm_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tick,
  input  logic [1:0]              cmpMode,
  input  logic [CNT_W-1:0]        countVal,
  input  logic                    cmpHit,
  output pcpwm_pkg::pwmStrobes_t  strobes
);
  import pcpwm_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_NEAR = CNT_MAX - CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  // dirUp: direction of the next step; low while sitting at the top
  logic dirUp;
  logic atTop, atBottom, nearTop, nearBottom;
  logic hitRising, hitFalling;

  assign atTop      = (countVal == CNT_MAX);
  assign atBottom   = (countVal == '0);
  assign nearTop    = (countVal == CNT_NEAR);
  assign nearBottom = (countVal == CNT_ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirUp <= 1'b1;
    end else if (tick) begin
      if (dirUp && nearTop)          dirUp <= 1'b0;
      else if (!dirUp && nearBottom) dirUp <= 1'b1;
    end
  end

  assign hitRising  = tick && cmpHit && dirUp;
  assign hitFalling = tick && cmpHit && !dirUp;

  always_comb begin
    strobes          = '0;
    strobes.tick     = tick;
    strobes.stepUp   = tick && dirUp;
    strobes.stepDown = tick && !dirUp;
    strobes.loadCmp  = tick && atTop;
    strobes.setMatch = tick && cmpHit;
    strobes.setOvf   = tick && atBottom;
    strobes.outEn    = cmpMode[1];
    case (outMode_e'(cmpMode))
      MODE_NONINV: begin
        strobes.clrOut = hitRising;
        strobes.setOut = hitFalling;
      end
      MODE_INV: begin
        strobes.setOut = hitRising;
        strobes.clrOut = hitFalling;
      end
      default: begin
        strobes.setOut = 1'b0;
        strobes.clrOut = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pcpwm_datapath.sv
module pcpwm_datapath #(
  parameter int CNT_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  pcpwm_pkg::pwmStrobes_t strobes,
  input  logic                   cmpWrEn,
  input  logic [CNT_W-1:0]       cmpWrData,
  input  logic                   matchClr,
  input  logic                   ovfClr,
  output logic [CNT_W-1:0]       countVal,
  output logic                   cmpHit,
  output logic                   pwmOut,
  output logic                   matchFlag,
  output logic                   ovfFlag
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmpHold;
  logic [CNT_W-1:0] cmpActive;
  logic             outState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cnt <= '0;
    else if (strobes.stepUp)   cnt <= cnt + CNT_W'(1);
    else if (strobes.stepDown) cnt <= cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cmpHold <= '0;
    else if (cmpWrEn) cmpHold <= cmpWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cmpActive <= '0;
    else if (strobes.loadCmp) cmpActive <= cmpHold;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               outState <= 1'b0;
    else if (strobes.setOut) outState <= 1'b1;
    else if (strobes.clrOut) outState <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchFlag <= 1'b0;
      ovfFlag   <= 1'b0;
    end else begin
      if (strobes.setMatch) matchFlag <= 1'b1;
      else if (matchClr)    matchFlag <= 1'b0;
      if (strobes.setOvf)   ovfFlag <= 1'b1;
      else if (ovfClr)      ovfFlag <= 1'b0;
    end
  end

  assign countVal = cnt;
  assign cmpHit   = (cnt == cmpActive);
  assign pwmOut   = outState && strobes.outEn;

endmodule

// File: rtl/pcpwm_top.sv
module pcpwm_top #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [2:0]       clkSel,
  input  logic [1:0]       cmpMode,
  input  logic             cmpWrEn,
  input  logic [CNT_W-1:0] cmpWrData,
  input  logic             matchClr,
  input  logic             ovfClr,
  output logic             pwmOut,
  output logic             matchFlag,
  output logic             ovfFlag
);
  import pcpwm_pkg::*;

  logic             tick;
  logic             cmpHit;
  logic [CNT_W-1:0] countVal;
  pwmStrobes_t      strobes;

  pcpwm_prescale #(.PRE_W(PRE_W)) prescale_i (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .clkSel (clkSel),
    .tick   (tick)
  );

  pcpwm_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .cmpMode  (cmpMode),
    .countVal (countVal),
    .cmpHit   (cmpHit),
    .strobes  (strobes)
  );

  pcpwm_datapath #(.CNT_W(CNT_W)) datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .cmpWrEn   (cmpWrEn),
    .cmpWrData (cmpWrData),
    .matchClr  (matchClr),
    .ovfClr    (ovfClr),
    .countVal  (countVal),
    .cmpHit    (cmpHit),
    .pwmOut    (pwmOut),
    .matchFlag (matchFlag),
    .ovfFlag   (ovfFlag)
  );

endmodule

// File: rtl/pcpwm_chk.sv
module pcpwm_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic [1:0]       cmpMode,
  input logic             matchClr,
  input logic             ovfClr,
  input logic             pwmOut,
  input logic             matchFlag,
  input logic             ovfFlag,
  input logic             tick,
  input logic [CNT_W-1:0] countVal
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R2
  turn_at_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && countVal == CNT_MAX) |=> (countVal == CNT_MAX - CNT_W'(1)));

  // R2
  turn_at_bottom_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && countVal == '0) |=> (countVal == CNT_W'(1)));

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && countVal != CNT_MAX && countVal != '0) |=>
      (countVal == $past(countVal) + CNT_W'(1) || countVal == $past(countVal) - CNT_W'(1)));

  // R1
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(countVal));

  // R11
  disabled_no_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !tick);

  // R3
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && countVal == '0) |=> ovfFlag);

  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag);

  // R3
  ovf_no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ovfFlag && !(tick && countVal == '0)) |=> !ovfFlag);

  // R4
  match_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchFlag && !matchClr) |=> matchFlag);

  // R7
  output_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmpMode[1] == 1'b0) |-> !pwmOut);

endmodule

bind pcpwm_top pcpwm_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .cmpMode   (cmpMode),
  .matchClr  (matchClr),
  .ovfClr    (ovfClr),
  .pwmOut    (pwmOut),
  .matchFlag (matchFlag),
  .ovfFlag   (ovfFlag),
  .tick      (tick),
  .countVal  (countVal)
);

// File: tb/pcpwm_top_tb.sv
`timescale 1ns/1ps
module pcpwm_top_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       enable;
  logic [2:0] clkSel;
  logic [1:0] cmpMode;
  logic       cmpWrEn;
  logic [7:0] cmpWrData;
  logic       matchClr;
  logic       ovfClr;
  logic       pwmOut;
  logic       matchFlag;
  logic       ovfFlag;

  int  vecs = 0;
  int  errs = 0;
  bit  finished = 0;
  bit  autoClr;

  // Reference state, written from the requirement text
  int         mCyc, mPos;
  bit         mOut, mMatch, mOvf;
  logic [7:0] mActive, mHold;

  always #10 clk = ~clk;

  pcpwm_top dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .clkSel(clkSel),
    .cmpMode(cmpMode), .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData),
    .matchClr(matchClr), .ovfClr(ovfClr),
    .pwmOut(pwmOut), .matchFlag(matchFlag), .ovfFlag(ovfFlag)
  );

  function automatic int divOf(logic [2:0] s);
    case (s)
      3'd1: return 1;
      3'd2: return 8;
      3'd3: return 64;
      3'd4: return 256;
      3'd5: return 1024;
      default: return 0;
    endcase
  endfunction

  task automatic checkBit(string tag, logic got, logic exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic checkInt(string tag, int got, int exp);
    vecs++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Apply one rising edge to the reference
  task automatic modelEdge();
    int  n;
    bit  tk, up, mSet, oSet;
    int  v;
    n  = divOf(clkSel);
    tk = enable && n != 0 && ((mCyc % n) == n - 1);
    mCyc = enable ? mCyc + 1 : 0;
    mSet = 0;
    oSet = 0;
    if (tk) begin
      v  = (mPos <= 255) ? mPos : 510 - mPos;
      up = (mPos < 255);
      if (v == int'(mActive)) begin
        mSet = 1;
        if (cmpMode == 2'd2) mOut = up ? 1'b0 : 1'b1;
        if (cmpMode == 2'd3) mOut = up ? 1'b1 : 1'b0;
      end
      if (v == 0)   oSet = 1;
      if (v == 255) mActive = mHold;
      mPos = (mPos + 1) % 510;
    end
    mMatch = mSet ? 1'b1 : (matchClr ? 1'b0 : mMatch);
    mOvf   = oSet ? 1'b1 : (ovfClr ? 1'b0 : mOvf);
    if (cmpWrEn) mHold = cmpWrData;
  endtask

  task automatic cyc(string tagOut, string tagFlag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    checkBit(tagOut, pwmOut, cmpMode[1] ? mOut : 1'b0);
    checkBit({tagFlag, " matchFlag"}, matchFlag, mMatch);
    checkBit({tagFlag, " ovfFlag"}, ovfFlag, mOvf);
    cmpWrEn  = 1'b0;
    matchClr = autoClr && matchFlag;
    ovfClr   = autoClr && ovfFlag;
  endtask

  task automatic doReset(logic [2:0] sel, logic [1:0] mode);
    @(negedge clk);
    rstN = 1'b0; enable = 1'b0; clkSel = sel; cmpMode = mode;
    cmpWrEn = 1'b0; cmpWrData = 8'd0; matchClr = 1'b0; ovfClr = 1'b0;
    autoClr = 1'b1;
    mCyc = 0; mPos = 0; mOut = 0; mMatch = 0; mOvf = 0;
    mActive = 8'd0; mHold = 8'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runCycles(int n, string tagOut, string tagFlag);
    for (int i = 0; i < n; i++) cyc(tagOut, tagFlag);
  endtask

  // R10: state straight after reset
  task automatic testReset();
    doReset(3'd1, 2'd2);
    checkBit("R10 pwmOut", pwmOut, 1'b0);
    checkBit("R10 matchFlag", matchFlag, 1'b0);
    checkBit("R10 ovfFlag", ovfFlag, 1'b0);
    runCycles(20, "R10 pwmOut", "R10");
  endtask

  // R1: first tick lands on the Nth edge; codes 0/6/7 never tick
  task automatic testPrescale();
    for (int s = 1; s <= 5; s++) begin
      int n;
      doReset(3'(s), 2'd2);
      autoClr = 1'b0;
      enable  = 1'b1;
      n = divOf(3'(s));
      if (n > 1) begin
        runCycles(n - 1, "R1 pwmOut", "R1");
        checkBit("R1 no tick before Nth edge", matchFlag, 1'b0);
      end
      cyc("R1 pwmOut", "R1");
      checkBit("R1 first tick sets matchFlag", matchFlag, 1'b1);
      checkBit("R1 first tick sets ovfFlag", ovfFlag, 1'b1);
    end
    for (int s = 0; s < 3; s++) begin
      logic [2:0] code;
      code = (s == 0) ? 3'd0 : 3'(5 + s);
      doReset(code, 2'd2);
      enable = 1'b1;
      runCycles(1100, "R1 pwmOut", "R1");
      checkBit("R1 stopped code matchFlag", matchFlag, 1'b0);
      checkBit("R1 stopped code ovfFlag", ovfFlag, 1'b0);
    end
  endtask

  // R5/R8/R4/R3: non-inverted run with a mid-period write
  task automatic testNonInverted();
    doReset(3'd1, 2'd2);
    cmpWrData = 8'd100; cmpWrEn = 1'b1;
    cyc("R5 pwmOut", "R4/R3");
    enable = 1'b1;
    runCycles(800, "R5 pwmOut", "R4/R3");
    cmpWrData = 8'd30; cmpWrEn = 1'b1;
    runCycles(1300, "R8 pwmOut after write", "R4/R3");
  endtask

  // R6: inverted levels
  task automatic testInverted();
    doReset(3'd1, 2'd3);
    cmpWrData = 8'd40; cmpWrEn = 1'b1;
    cyc("R6 pwmOut", "R4");
    enable = 1'b1;
    runCycles(1600, "R6 pwmOut", "R4");
  endtask

  // R9: extreme compare values, then a whole period at a fixed level
  task automatic testExtremes();
    for (int m = 2; m <= 3; m++) begin
      for (int e = 0; e < 2; e++) begin
        logic [7:0] val;
        int         highs;
        logic       lvl;
        val = (e == 0) ? 8'd0 : 8'd255;
        doReset(3'd1, 2'(m));
        cmpWrData = val; cmpWrEn = 1'b1;
        cyc("R9 pwmOut", "R4");
        enable = 1'b1;
        runCycles(1100, "R9 pwmOut", "R4");
        highs = 0;
        for (int i = 0; i < 510; i++) begin
          cyc("R9 pwmOut", "R4");
          if (pwmOut) highs++;
        end
        lvl = ((m == 2) == (e == 1));
        checkInt("R9 high cycles per period", highs, lvl ? 510 : 0);
      end
    end
  endtask

  // R7: modes 0 and 1 keep the output low while flags still run
  task automatic testModeOff();
    for (int m = 0; m < 2; m++) begin
      int seen;
      doReset(3'd1, 2'(m));
      cmpWrData = 8'd100; cmpWrEn = 1'b1;
      cyc("R7 pwmOut", "R7");
      enable = 1'b1;
      seen = 0;
      for (int i = 0; i < 1100; i++) begin
        cyc("R7 pwmOut", "R7");
        if (matchFlag) seen++;
      end
      checkBit("R7 pwmOut low", pwmOut, 1'b0);
      checkInt("R7 flags still set (match events)", (seen >= 3) ? 1 : 0, 1);
    end
  endtask

  // R11: freeze while disabled
  task automatic testFreeze();
    logic held;
    doReset(3'd1, 2'd2);
    cmpWrData = 8'd100; cmpWrEn = 1'b1;
    cyc("R11 pwmOut", "R11");
    enable = 1'b1;
    runCycles(700, "R11 pwmOut", "R11");
    enable = 1'b0;
    runCycles(3, "R11 pwmOut", "R11");
    held = pwmOut;
    for (int i = 0; i < 300; i++) begin
      cyc("R11 pwmOut", "R11");
      checkBit("R11 output frozen", pwmOut, held);
      checkBit("R11 no flag while frozen", ovfFlag | matchFlag, 1'b0);
    end
    enable = 1'b1;
    runCycles(600, "R11 pwmOut resumed", "R11");
  endtask

  // R2/R5: measure period and high width at the ports
  task automatic testPeriod(logic [2:0] sel, logic [7:0] k);
    int n, rise1, rise2, fall, limit;
    logic prev;
    n = divOf(sel);
    doReset(sel, 2'd2);
    cmpWrData = k; cmpWrEn = 1'b1;
    cyc("R2 pwmOut", "R3");
    enable = 1'b1;
    rise1 = -1; rise2 = -1; fall = -1;
    limit = 3 * 510 * n;
    for (int i = 0; i < limit; i++) begin
      prev = pwmOut;
      cyc("R2 pwmOut", "R3");
      if (!prev && pwmOut) begin
        if (rise1 < 0) rise1 = i;
        else if (rise2 < 0) rise2 = i;
      end
      if (prev && !pwmOut && rise1 >= 0 && fall < 0) fall = i;
    end
    checkInt("R2 period in cycles", rise2 - rise1, 510 * n);
    checkInt("R5 high width in cycles", fall - rise1, 2 * int'(k) * n);
  endtask

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; enable = 1'b0; clkSel = 3'd0; cmpMode = 2'd0;
    cmpWrEn = 1'b0; cmpWrData = 8'd0; matchClr = 1'b0; ovfClr = 1'b0;
    autoClr = 1'b1;
    testReset();
    testPrescale();
    testNonInverted();
    testInverted();
    testExtremes();
    testModeOff();
    testFreeze();
    testPeriod(3'd1, 8'd100);
    testPeriod(3'd1, 8'd37);
    testPeriod(3'd2, 8'd60);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule